// File: doc/BRIEF.md
# Emulation Test-Mode Entry Detector

This block decides, at the moment the chip leaves reset, whether the controller starts normally or hands its pins to an external emulator or test processor. While the reset pin is held, it watches the address-latch strobe and the program-store strobe. If the latch strobe is held low and the program strobe stays high for a configurable number of clocks, the entry is qualified. The latch strobe must still be low in the clock where reset is released. When both conditions hold, the block sets a sticky test-mode flag.

While the flag is set, the block stops the CPU from running and keeps the oscillator forced on. It also drives the pad controls. One port group is fully released, so it floats. Every other port group, and the two strobe pins, lose their active drivers and keep only a weak pull-up. The flag stays set whatever the pins do afterwards, and only the next assertion of the reset pin clears it. The three pin inputs are brought into the clock domain through a two-stage synchroniser before any decision is made, and an asynchronous power-on reset initialises every flop.

Top module: `emu_mode_entry`

## Requirements
- R1: While `por_n` is low, and in the first cycles after it rises with the reset pin high, `tm_active`, `cpu_run_en`, `osc_force_on` and every pad-control output are 0.
- R2: Each pin passes through two synchroniser flops. Entry is qualified only after the synchronised view shows reset high, ALE low and PSEN high for QUAL_CYCLES consecutive clocks (default 4). A run of QUAL_CYCLES-1 clocks does not qualify.
- R3: `tm_active` rises only in the clock after the synchronised reset falls, and only if the entry was qualified at that point.
- R4: If the synchronised ALE goes high or PSEN goes low while reset is held, the qualification count restarts. Reset then releases into normal operation unless a fresh full run completes.
- R5: A qualified entry is discarded if ALE is high in the clock where reset is released.
- R6: While in the mode, port group FLOAT_PORT (default bit 0 of the port vectors) has `port_drv_dis`=1 and `port_weak_pu`=0, so it floats.
- R7: While in the mode, every other port group has `port_drv_dis`=1 and `port_weak_pu`=1. Both strobe controls (bit 0 ALE, bit 1 PSEN) of `ctl_drv_dis` and `ctl_weak_pu` are 1.
- R8: `osc_force_on` is 1 exactly while `tm_active` is 1.
- R9: `cpu_run_en` is 1 only when the synchronised reset is low and the mode is not set.
- R10: Once set, the mode holds through any ALE/PSEN activity while reset stays low. It clears on the clock after the synchronised reset is seen high.
- R11: Outside the mode, all pad-control outputs are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock |
| por_n | input | 1 | Asynchronous power-on reset, active low |
| rst_pin | input | 1 | External reset pin level, active high, asynchronous |
| ale_pin | input | 1 | Address-latch strobe pin level, asynchronous |
| psen_pin | input | 1 | Program-store strobe pin level, asynchronous |
| tm_active | output | 1 | Latched test-mode flag |
| cpu_run_en | output | 1 | CPU run enable |
| osc_force_on | output | 1 | Keeps the oscillator running |
| port_drv_dis | output | NPORTS | Per-port active-driver disable |
| port_weak_pu | output | NPORTS | Per-port weak pull-up enable |
| ctl_drv_dis | output | 2 | Driver disable for ALE (bit 0) and PSEN (bit 1) |
| ctl_weak_pu | output | 2 | Weak pull-up for ALE (bit 0) and PSEN (bit 1) |

## Verification
The bench aims at the qualification boundary with runs of exactly QUAL_CYCLES and QUAL_CYCLES-1 clocks. An off-by-one counter would enter on the short run or refuse the full one. It breaks a long run with a one-clock ALE rise and, separately, a one-clock PSEN drop. A counter that never restarts would then enter from a stale count. It also releases reset in the same clock that ALE rises, which catches a design that checks ALE a cycle late or not at all. Finally, it toggles the strobes while in the mode and then re-asserts reset, which exposes a flag that follows the pins or misses its exit, and a float/pull-up split applied to the wrong port.

// File: rtl/emu_mode_pkg.sv
package emu_mode_pkg;

  // Bit positions of the three pins inside the synchroniser vector
  localparam int unsigned PIN_ALE  = 0;
  localparam int unsigned PIN_PSEN = 1;
  localparam int unsigned PIN_RST  = 2;
  localparam int unsigned PIN_W    = 3;

  // Saturating increment used by the qualification counter
  function automatic int unsigned sat_inc(input int unsigned v, input int unsigned lim);
    return (v >= lim) ? lim : v + 1;
  endfunction

  // Entry decision on a reset release clock
  function automatic logic entry_ok(input logic rst_prev, input logic rst_now,
                                    input logic qual, input logic ale_now);
    return rst_prev && !rst_now && qual && !ale_now;
  endfunction

endpackage

// File: rtl/emu_pin_sync.sv
module emu_pin_sync #(
  parameter int unsigned W       = 3,
  parameter int unsigned STAGES  = 2,
  parameter logic [W-1:0] RST_VAL = '1
) (
  input  logic         clk,
  input  logic         por_n,
  input  logic [W-1:0] d,
  output logic [W-1:0] q
);
  logic [STAGES-1:0][W-1:0] stg;

  always_ff @(posedge clk or negedge por_n) begin
    if (!por_n) stg <= {STAGES{RST_VAL}};
    else        stg <= {stg[STAGES-2:0], d};
  end

  assign q = stg[STAGES-1];
endmodule

// File: rtl/emu_qualifier.sv
module emu_qualifier #(
  parameter int unsigned QUAL_CYCLES = 4
) (
  input  logic clk,
  input  logic por_n,
  input  logic rst_s,
  input  logic ale_s,
  input  logic psen_s,
  output logic qualified
);
  localparam int unsigned CW = $clog2(QUAL_CYCLES + 1);

  logic [CW-1:0] cnt_q;
  logic          cond_hold;

  assign cond_hold = rst_s && !ale_s && psen_s;

  always_ff @(posedge clk or negedge por_n) begin
    if (!por_n)         cnt_q <= '0;
    else if (cond_hold) cnt_q <= CW'(emu_mode_pkg::sat_inc(32'(cnt_q), QUAL_CYCLES));
    else                cnt_q <= '0;
  end

  assign qualified = (cnt_q == CW'(QUAL_CYCLES));

  // R4: a broken condition drops the qualification next clock
  p_break_clears_r4: assert property (@(posedge clk) disable iff (!por_n)
    (rst_s && (ale_s || !psen_s)) |=> !qualified) else $error("p_break_clears_r4");

  // R2: qualification holds while the condition holds
  p_qual_sticky_r2: assert property (@(posedge clk) disable iff (!por_n)
    (qualified && cond_hold) |=> qualified) else $error("p_qual_sticky_r2");
endmodule

// File: rtl/emu_mode_latch.sv
module emu_mode_latch (
  input  logic clk,
  input  logic por_n,
  input  logic rst_s,
  input  logic ale_s,
  input  logic qualified,
  output logic mode
);
  logic rst_prev_q;
  logic mode_q;
  logic release_evt;
  logic enter_evt;

  assign release_evt = rst_prev_q && !rst_s;
  assign enter_evt   = emu_mode_pkg::entry_ok(rst_prev_q, rst_s, qualified, ale_s);

  always_ff @(posedge clk or negedge por_n) begin
    if (!por_n) begin
      rst_prev_q <= 1'b1;
      mode_q     <= 1'b0;
    end else begin
      rst_prev_q <= rst_s;
      if (rst_s)          mode_q <= 1'b0;
      else if (enter_evt) mode_q <= 1'b1;
    end
  end

  assign mode = mode_q;

  // R3: entry only on a qualified release clock
  p_entry_on_release_r3: assert property (@(posedge clk) disable iff (!por_n)
    $rose(mode_q) |-> $past(release_evt && qualified)) else $error("p_entry_on_release_r3");

  // R5: ALE must be low on the release clock
  p_entry_ale_low_r5: assert property (@(posedge clk) disable iff (!por_n)
    $rose(mode_q) |-> $past(!ale_s)) else $error("p_entry_ale_low_r5");

  // R10: reset exits the mode
  p_exit_on_reset_r10: assert property (@(posedge clk) disable iff (!por_n)
    (mode_q && rst_s) |=> !mode_q) else $error("p_exit_on_reset_r10");

  // R10: mode holds while reset stays low
  p_hold_r10: assert property (@(posedge clk) disable iff (!por_n)
    (mode_q && !rst_s) |=> mode_q) else $error("p_hold_r10");
endmodule

// File: rtl/emu_pad_override.sv
module emu_pad_override #(
  parameter int unsigned NPORTS     = 4,
  parameter int unsigned FLOAT_PORT = 0
) (
  input  logic              mode,
  output logic [NPORTS-1:0] port_drv_dis,
  output logic [NPORTS-1:0] port_weak_pu,
  output logic [1:0]        ctl_drv_dis,
  output logic [1:0]        ctl_weak_pu
);
  for (genvar p = 0; p < NPORTS; p++) begin : g_port
    if (p == FLOAT_PORT) begin : g_float
      assign port_drv_dis[p] = mode;
      assign port_weak_pu[p] = 1'b0;
    end else begin : g_pull
      assign port_drv_dis[p] = mode;
      assign port_weak_pu[p] = mode;
    end
  end

  assign ctl_drv_dis = {2{mode}};
  assign ctl_weak_pu = {2{mode}};
endmodule

// File: rtl/emu_mode_entry.sv
module emu_mode_entry #(
  parameter int unsigned NPORTS      = 4,
  parameter int unsigned FLOAT_PORT  = 0,
  parameter int unsigned QUAL_CYCLES = 4,
  parameter int unsigned SYNC_STAGES = 2
) (
  input  logic              clk,
  input  logic              por_n,
  input  logic              rst_pin,
  input  logic              ale_pin,
  input  logic              psen_pin,
  output logic              tm_active,
  output logic              cpu_run_en,
  output logic              osc_force_on,
  output logic [NPORTS-1:0] port_drv_dis,
  output logic [NPORTS-1:0] port_weak_pu,
  output logic [1:0]        ctl_drv_dis,
  output logic [1:0]        ctl_weak_pu
);
  import emu_mode_pkg::*;

  logic [PIN_W-1:0] pins_raw;
  logic [PIN_W-1:0] pins_s;
  logic             rst_s;
  logic             ale_s;
  logic             psen_s;
  logic             qualified;
  logic             mode;

  always_comb begin
    pins_raw           = '0;
    pins_raw[PIN_ALE]  = ale_pin;
    pins_raw[PIN_PSEN] = psen_pin;
    pins_raw[PIN_RST]  = rst_pin;
  end

  emu_pin_sync #(.W(PIN_W), .STAGES(SYNC_STAGES), .RST_VAL('1)) u_sync (
    .clk(clk), .por_n(por_n), .d(pins_raw), .q(pins_s));

  assign ale_s  = pins_s[PIN_ALE];
  assign psen_s = pins_s[PIN_PSEN];
  assign rst_s  = pins_s[PIN_RST];

  emu_qualifier #(.QUAL_CYCLES(QUAL_CYCLES)) u_qual (
    .clk(clk), .por_n(por_n), .rst_s(rst_s), .ale_s(ale_s), .psen_s(psen_s),
    .qualified(qualified));

  emu_mode_latch u_latch (
    .clk(clk), .por_n(por_n), .rst_s(rst_s), .ale_s(ale_s),
    .qualified(qualified), .mode(mode));

  emu_pad_override #(.NPORTS(NPORTS), .FLOAT_PORT(FLOAT_PORT)) u_pad (
    .mode(mode), .port_drv_dis(port_drv_dis), .port_weak_pu(port_weak_pu),
    .ctl_drv_dis(ctl_drv_dis), .ctl_weak_pu(ctl_weak_pu));

  assign tm_active    = mode;
  assign osc_force_on = mode;
  assign cpu_run_en   = !rst_s && !mode;

  // R9: CPU never runs in the test mode
  p_run_blocked_r9: assert property (@(posedge clk) disable iff (!por_n)
    tm_active |-> !cpu_run_en) else $error("p_run_blocked_r9");

  // R6: float port is released with no pull
  p_float_port_r6: assert property (@(posedge clk) disable iff (!por_n)
    tm_active |-> (port_drv_dis[FLOAT_PORT] && !port_weak_pu[FLOAT_PORT]))
    else $error("p_float_port_r6");

  // R11: no override outside the mode
  p_quiet_r11: assert property (@(posedge clk) disable iff (!por_n)
    !tm_active |-> (port_drv_dis == '0 && port_weak_pu == '0 && ctl_drv_dis == '0))
    else $error("p_quiet_r11");
endmodule

// File: tb/emu_mode_entry_bench.sv
module emu_mode_entry_bench;
  localparam int NP   = 4;
  localparam int QUAL = 4;

  logic clk = 1'b0;
  logic por_n = 1'b0;
  logic rst_pin = 1'b1, ale_pin = 1'b1, psen_pin = 1'b1;
  logic tm_active, cpu_run_en, osc_force_on;
  logic [NP-1:0] port_drv_dis, port_weak_pu;
  logic [1:0] ctl_drv_dis, ctl_weak_pu;

  int checks = 0, fails = 0, cycles = 0;
  bit done = 0;

  always #10 clk = ~clk;

  emu_mode_entry #(.NPORTS(NP), .FLOAT_PORT(0), .QUAL_CYCLES(QUAL), .SYNC_STAGES(2)) u_emu_mode_entry (
    .clk(clk), .por_n(por_n), .rst_pin(rst_pin), .ale_pin(ale_pin), .psen_pin(psen_pin),
    .tm_active(tm_active), .cpu_run_en(cpu_run_en), .osc_force_on(osc_force_on),
    .port_drv_dis(port_drv_dis), .port_weak_pu(port_weak_pu),
    .ctl_drv_dis(ctl_drv_dis), .ctl_weak_pu(ctl_weak_pu));

  // Behavioural reference: pin histories as queues, integer counter
  bit qr[$], qa[$], qp[$];
  int ref_cnt = 0;
  bit ref_mode = 0;
  bit ref_rs = 1;

  task automatic ref_clear();
    qr = '{1, 1, 1}; qa = '{1, 1, 1}; qp = '{1, 1, 1};
    ref_cnt = 0; ref_mode = 0; ref_rs = 1;
  endtask

  initial ref_clear();

  always @(posedge clk) begin
    if (!por_n) ref_clear();
    else begin
      bit rp, rs, as_, ps, q;
      rp = qr[0]; rs = qr[1]; as_ = qa[1]; ps = qp[1];
      q = (ref_cnt == QUAL);
      if (rs) ref_mode = 0;
      else if (rp && q && !as_) ref_mode = 1;
      if (rs && !as_ && ps) ref_cnt = (ref_cnt < QUAL) ? ref_cnt + 1 : QUAL;
      else ref_cnt = 0;
      qr.push_back(rst_pin);  void'(qr.pop_front());
      qa.push_back(ale_pin);  void'(qa.pop_front());
      qp.push_back(psen_pin); void'(qp.pop_front());
      ref_rs = qr[1];
    end
  end

  task automatic chk(input string tag, input int got, input int exp);
    checks++;
    if (got != exp) begin
      fails++;
      $display("FAIL %s: got %0h expected %0h at cycle %0d", tag, got, exp, cycles);
    end
  endtask

  // Per-clock comparison against the reference, away from the active edge
  always @(negedge clk) begin
    cycles++;
    if (!done) begin
      chk("R3/R10 tm_active", tm_active, ref_mode);
      chk("R9 cpu_run_en", cpu_run_en, !ref_rs && !ref_mode);
      chk("R8 osc_force_on", osc_force_on, ref_mode);
      chk("R6/R7 port_drv_dis", port_drv_dis, ref_mode ? 4'hF : 4'h0);
      chk("R6/R7 port_weak_pu", port_weak_pu, ref_mode ? 4'hE : 4'h0);
      chk("R7 ctl_drv_dis", ctl_drv_dis, ref_mode ? 2'b11 : 2'b00);
      chk("R7 ctl_weak_pu", ctl_weak_pu, ref_mode ? 2'b11 : 2'b00);
    end
  end

  task automatic cyc(input int n);
    repeat (n) @(negedge clk);
  endtask

  // Hold reset with idle strobes, then ALE low for n clocks, then release
  task automatic attempt(input int n, input bit ale_at_release);
    rst_pin = 1; ale_pin = 1; psen_pin = 1; cyc(6);
    ale_pin = 0; cyc(n);
    rst_pin = 0; ale_pin = ale_at_release; cyc(3);
    ale_pin = 1; cyc(3);
  endtask

  task automatic in_mode(input string tag);
    chk({tag, " tm_active set"}, tm_active, 1);
    chk("R6 float port", {port_drv_dis[0], port_weak_pu[0]}, 2'b10);
    chk("R7 pulled ports", {port_drv_dis[3:1], port_weak_pu[3:1]}, 6'b111111);
    chk("R7 strobe pins", {ctl_drv_dis, ctl_weak_pu}, 4'b1111);
    chk("R8 oscillator held", osc_force_on, 1);
    chk("R9 run held low", cpu_run_en, 0);
  endtask

  task automatic normal(input string tag);
    chk({tag, " tm_active clear"}, tm_active, 0);
    chk("R11 overrides idle", {port_drv_dis, port_weak_pu, ctl_drv_dis, ctl_weak_pu}, 0);
    chk("R9 run enabled", cpu_run_en, 1);
  endtask

  initial begin
    cyc(3);
    // R1: power-on state
    chk("R1 tm_active", tm_active, 0);
    chk("R1 cpu_run_en", cpu_run_en, 0);
    chk("R1 pads", {osc_force_on, port_drv_dis, port_weak_pu, ctl_drv_dis, ctl_weak_pu}, 0);
    por_n = 1; cyc(4);
    chk("R1 after por", {tm_active, cpu_run_en}, 0);

    // R2/R3: exact qualification length enters
    attempt(QUAL, 0);
    in_mode("R3");
    // R10: strobe activity does not disturb the mode
    for (int i = 0; i < 10; i++) begin
      ale_pin = i[0]; psen_pin = i[1]; cyc(1);
      chk("R10 hold under toggling", tm_active, 1);
    end
    // R10: reset exits
    ale_pin = 1; psen_pin = 1; rst_pin = 1; cyc(4);
    chk("R10 exit on reset", tm_active, 0);
    chk("R9 run low in reset", cpu_run_en, 0);
    rst_pin = 0; cyc(4);
    normal("R10");

    // R2: one clock short does not enter
    attempt(QUAL - 1, 0);
    normal("R2");

    // R4: ALE glitch restarts count
    rst_pin = 1; cyc(6); ale_pin = 0; cyc(8); ale_pin = 1; cyc(1); ale_pin = 0; cyc(2);
    rst_pin = 0; cyc(3); ale_pin = 1; cyc(3);
    normal("R4 ale");
    // R4: PSEN drop restarts count
    rst_pin = 1; cyc(6); ale_pin = 0; cyc(8); psen_pin = 0; cyc(1); psen_pin = 1; cyc(2);
    rst_pin = 0; cyc(3); ale_pin = 1; cyc(3);
    normal("R4 psen");

    // R5: ALE high on the release clock
    attempt(8, 1);
    normal("R5");

    // Long qualification enters again, then leave
    attempt(12, 0);
    in_mode("R3 long");
    rst_pin = 1; cyc(5); rst_pin = 0; cyc(4);
    normal("R10 second");

    done = 1;
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    cyc(20000);
    if (!done) begin
      done = 1;
      checks++; fails++;
      $display("FAIL watchdog: got hang expected completion");
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end
endmodule